// File: doc/BRIEF.md
# Overlay Horizontal Dot Timing Generator

This block produces the horizontal timing of a character overlay. It runs from a pixel clock that an external loop keeps at a fixed multiple of the line rate. A falling edge on the active-low horizontal sync starts a programmable lead-in. The lead-in is `POS_BASE + hpos × POS_STEP` pixel clocks, which is 61 + 6·hpos with the defaults. At its end the block opens a display window of 24 character cells, each 12 dots wide. During the window it reports the current cell and the dot inside that cell.

A 12-bit glyph row is taken in once per cell. The block serialises it most-significant bit first, one dot per displayed pixel. A strobe marks the exact cycle in which the row is sampled, so that glyph-fetch logic outside the block can present the row for the next cell. A double-width control stretches every dot over two clocks, which doubles the window. The lead-in and the width mode are both captured at the sync edge, so each line is fixed from its start.

Top module: `osd_hpix_timing`

## Requirements
- R1: Only a high-to-low change of `hsync_n` (sampled on `clk`) starts a line. Holding `hsync_n` low for many clocks, or raising it, starts nothing new.
- R2: `hact_o` goes high on the S-th rising clock edge after the edge that first samples `hsync_n` low, where S = 61 + 6·`hpos`. At that point `col_o` and `dot_o` both read 0.
- R3: `hpos` and `dbl_w` are captured on the edge that detects the sync fall. Changing them afterwards has no effect on the current line.
- R4: With `dbl_w`=0, the window lasts 288 clocks. `dot_o` steps 0..11 once per clock, and `col_o` steps 0..23, once every 12 clocks.
- R5: With `dbl_w`=1, every dot value is held for two clocks, `col_o` advances every 24 clocks, and the window lasts 576 clocks.
- R6: While `hact_o` is low, `col_o` and `dot_o` read 0. After the last dot of cell 23, the window stays closed until the next sync fall.
- R7: `font_ld_o` is high in exactly one cycle per cell: the cycle before the cell's dot 0. `font_row` is sampled at the end of that cycle. During dot d of the cell, `pix_o` equals bit 11−d of the sampled row (bit 11 first).
- R8: `pix_o` is 0 whenever `hact_o` is 0.
- R9: A sync fall that arrives during the lead-in or during the window restarts the line. `hact_o` is low in the following cycle, and the lead-in is counted again from that edge.
- R10: While `rst_n` is low at a rising edge (synchronous, active low), the block returns to idle. After that edge `hact_o`, `pix_o` and `font_ld_o` are 0, and `col_o` and `dot_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low, synchronous to `clk` |
| hpos | input | 5 | Horizontal start position code |
| dbl_w | input | 1 | Double-width mode select |
| font_row | input | 12 | Glyph row for the next cell |
| hact_o | output | 1 | Display window active |
| col_o | output | 5 | Character cell index, 0..23 |
| dot_o | output | 4 | Dot index within the cell, 0..11 |
| pix_o | output | 1 | Serialised glyph pixel |
| font_ld_o | output | 1 | Glyph row is sampled at the end of this cycle |

## Verification
The bench sweeps every position code in both width modes. It compares each output on every cycle against an arithmetic model of the line, and it changes `hpos` and `dbl_w` right after each sync edge. An off-by-one in the lead-in shifts the whole window by a pixel, and a late capture of the controls shows up as a window at the wrong place. The glyph input carries the correct row only in the one cycle where it should be sampled, and carries unrelated values in every other cycle. A design that loads on the wrong dot, or reloads during a cell, therefore serialises the wrong bits. Separate lines check three more cases: a sync that is held low across the window start, which must not restart the line; a restart during the lead-in and a restart during the window; and a reset in the middle of a line.

// File: rtl/osd_hpix_pkg.sv
// Shared types and helpers for the overlay horizontal timing block.
// Assumes: callers pass small, non-negative position parameters.
package osd_hpix_pkg;

    // Lead-in counter phase
    typedef enum logic {
        DLY_IDLE  = 1'b0,
        DLY_COUNT = 1'b1
    } dly_state_e;

    // Lead-in length in pixel clocks for a given position code
    function automatic int unsigned lead_in_len(input int unsigned pos_code,
                                                input int unsigned step,
                                                input int unsigned base);
        return base + pos_code * step;
    endfunction

endpackage

// File: rtl/osd_hsync_fall.sv
// Detects the high-to-low transition of the active-low horizontal sync.
// Assumes: hsync_n is already synchronous to clk; a reset value of 1 means
// a sync held low across reset release counts as a fresh edge.
module osd_hsync_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n_i,
    output logic fall_o
);

    logic hs_q;

    // Remember the previous sync level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1;
        end else begin
            hs_q <= hsync_n_i;
        end
    end

    // A fall is a high previous level with a low present level
    assign fall_o = hs_q & ~hsync_n_i;

endmodule

// File: rtl/osd_hstart_delay.sv
// Counts the programmable lead-in from the sync fall to the first displayed
// pixel and holds the width mode for the line.
// Assumes: the lead-in length is at least 1 and fits in CW bits.
module osd_hstart_delay
    import osd_hpix_pkg::*;
#(
    parameter int unsigned POS_W    = 5,
    parameter int unsigned POS_STEP = 6,
    parameter int unsigned POS_BASE = 61,
    parameter int unsigned CW       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [POS_W-1:0] hpos_i,
    input  logic             dbl_i,
    output logic             start_o,
    output logic             dbl_o
);

    dly_state_e      st;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   lead_len;
    logic            dbl_q;

    // Lead-in length for the position code present at the sync edge
    assign lead_len = CW'(lead_in_len(int'(hpos_i), POS_STEP, POS_BASE));

    // Load on a sync fall, then count down to the start of the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= DLY_IDLE;
            cnt   <= '0;
            dbl_q <= 1'b0;
        end else if (fall_i) begin
            st    <= DLY_COUNT;
            cnt   <= lead_len;
            dbl_q <= dbl_i;
        end else if (st == DLY_COUNT) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                st <= DLY_IDLE;
            end
        end
    end

    // The window opens on the edge that ends the last lead-in clock
    assign start_o = (st == DLY_COUNT) && (cnt == CW'(1)) && !fall_i;
    assign dbl_o   = dbl_q;

endmodule

// File: rtl/osd_dot_seq.sv
// Steps the dot and cell indices across the display window and tells the
// serialiser when to advance and when to take a new glyph row.
// Assumes: start_i only pulses while the window is closed.
module osd_dot_seq #(
    parameter int unsigned CHARS  = 24,
    parameter int unsigned DOT_W  = 12,
    parameter int unsigned COL_W  = 5,
    parameter int unsigned DOT_IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              dbl_i,
    output logic              act_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DOT_IW-1:0] dot_o,
    output logic              adv_o,
    output logic              load_o
);

    logic              act;
    logic              ph;
    logic [COL_W-1:0]  col;
    logic [DOT_IW-1:0] dot;
    logic              last_dot;
    logic              last_col;

    // Position decode for the end of a cell and the end of the row
    assign last_dot = (dot == DOT_IW'(DOT_W - 1));
    assign last_col = (col == COL_W'(CHARS - 1));

    // A dot advances every clock, or every second clock in double width
    assign adv_o  = act && (!dbl_i || ph);

    // A new row is needed at window start and at every cell boundary
    assign load_o = !fall_i && (start_i || (adv_o && last_dot && !last_col));

    // Window, phase and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            ph  <= 1'b0;
            col <= '0;
            dot <= '0;
        end else if (fall_i) begin
            act <= 1'b0;
            ph  <= 1'b0;
            col <= '0;
            dot <= '0;
        end else if (start_i) begin
            act <= 1'b1;
            ph  <= 1'b0;
            col <= '0;
            dot <= '0;
        end else if (act) begin
            ph <= dbl_i && !ph;
            if (adv_o) begin
                if (last_dot) begin
                    dot <= '0;
                    if (last_col) begin
                        act <= 1'b0;
                        col <= '0;
                    end else begin
                        col <= col + COL_W'(1);
                    end
                end else begin
                    dot <= dot + DOT_IW'(1);
                end
            end
        end
    end

    assign act_o = act;
    assign col_o = col;
    assign dot_o = dot;

endmodule

// File: rtl/osd_font_shift.sv
// Serialises one glyph row, most significant bit first, and blanks the
// output outside the display window.
// Assumes: load_i wins over shift_i when both are high.
module osd_font_shift #(
    parameter int unsigned DOT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             act_i,
    input  logic [DOT_W-1:0] row_i,
    output logic             pix_o
);

    logic [DOT_W-1:0] sr;

    // Take a new row at a cell boundary, otherwise move one dot on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load_i) begin
            sr <= row_i;
        end else if (shift_i) begin
            sr <= {sr[DOT_W-2:0], 1'b0};
        end
    end

    // Present the leading bit only while the window is open
    assign pix_o = act_i & sr[DOT_W-1];

endmodule

// File: rtl/osd_hpix_timing.sv
// Top of the overlay horizontal timing block: sync-edge detection, lead-in
// counter, dot/cell sequencer and glyph-row serialiser.
// Assumes: clk is the pixel clock locked to the line; all inputs are
// synchronous to clk.
module osd_hpix_timing #(
    parameter int unsigned LINE_DOTS = 384,
    parameter int unsigned CHARS     = 24,
    parameter int unsigned DOT_W     = 12,
    parameter int unsigned POS_W     = 5,
    parameter int unsigned POS_STEP  = 6,
    parameter int unsigned POS_BASE  = 61,
    localparam int unsigned COL_W    = $clog2(CHARS),
    localparam int unsigned DOT_IW   = $clog2(DOT_W),
    localparam int unsigned CW       = $clog2(LINE_DOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_n,
    input  logic [POS_W-1:0]  hpos,
    input  logic              dbl_w,
    input  logic [DOT_W-1:0]  font_row,
    output logic              hact_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DOT_IW-1:0] dot_o,
    output logic              pix_o,
    output logic              font_ld_o
);

    logic fall_w;
    logic start_w;
    logic dbl_w_q;
    logic adv_w;
    logic load_w;

    osd_hsync_fall u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n_i (hsync_n),
        .fall_o    (fall_w)
    );

    osd_hstart_delay #(
        .POS_W    (POS_W),
        .POS_STEP (POS_STEP),
        .POS_BASE (POS_BASE),
        .CW       (CW)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_w),
        .hpos_i  (hpos),
        .dbl_i   (dbl_w),
        .start_o (start_w),
        .dbl_o   (dbl_w_q)
    );

    osd_dot_seq #(
        .CHARS  (CHARS),
        .DOT_W  (DOT_W),
        .COL_W  (COL_W),
        .DOT_IW (DOT_IW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_w),
        .start_i (start_w),
        .dbl_i   (dbl_w_q),
        .act_o   (hact_o),
        .col_o   (col_o),
        .dot_o   (dot_o),
        .adv_o   (adv_w),
        .load_o  (load_w)
    );

    osd_font_shift #(
        .DOT_W (DOT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (adv_w),
        .act_i   (hact_o),
        .row_i   (font_row),
        .pix_o   (pix_o)
    );

    assign font_ld_o = load_w;

endmodule

// File: rtl/osd_hpix_timing_chk.sv
// Property checker for the overlay horizontal timing block, bound to the top.
// Assumes: it sees the sync-fall strobe, latched width mode and load strobe
// from inside the top.
module osd_hpix_timing_chk #(
    parameter int unsigned CHARS  = 24,
    parameter int unsigned DOT_W  = 12,
    parameter int unsigned COL_W  = 5,
    parameter int unsigned DOT_IW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fall,
    input logic              dbl_q,
    input logic              load,
    input logic              hact,
    input logic [COL_W-1:0]  col,
    input logic [DOT_IW-1:0] dot,
    input logic              pix
);

    // R9
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !hact);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hact |-> (col == '0 && dot == '0));

    // R8
    dark_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hact |-> !pix);

    // R4
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hact |-> (col <= COL_W'(CHARS - 1) && dot <= DOT_IW'(DOT_W - 1)));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hact && $past(hact) && !dbl_q) |-> !$stable(dot));

    // R5
    double_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hact && $past(hact) && dbl_q && !$stable(dot)) |=> (!hact || $stable(dot)));

    // R7
    load_first_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hact && dot == '0));

    // R2
    window_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hact) |-> (col == '0 && dot == '0));

endmodule

bind osd_hpix_timing osd_hpix_timing_chk #(
    .CHARS  (CHARS),
    .DOT_W  (DOT_W),
    .COL_W  (COL_W),
    .DOT_IW (DOT_IW)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .fall  (fall_w),
    .dbl_q (dbl_w_q),
    .load  (load_w),
    .hact  (hact_o),
    .col   (col_o),
    .dot   (dot_o),
    .pix   (pix_o)
);

// File: tb/osd_hpix_timing_tb_top.sv
`timescale 1ns/1ps
module osd_hpix_timing_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hsync_n;
    logic [4:0]  hpos;
    logic        dbl_w;
    logic [11:0] font_row;
    logic        hact_o;
    logic [4:0]  col_o;
    logic [3:0]  dot_o;
    logic        pix_o;
    logic        font_ld_o;

    int vecs = 0;
    int errs = 0;

    // Line model: lead-in, width factor, edges since the sync fall
    bit gvalid = 1'b0;
    int gS = 0;
    int gw = 1;
    int gn = 0;

    always #2.5 clk = ~clk;

    osd_hpix_timing dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n   (hsync_n),
        .hpos      (hpos),
        .dbl_w     (dbl_w),
        .font_row  (font_row),
        .hact_o    (hact_o),
        .col_o     (col_o),
        .dot_o     (dot_o),
        .pix_o     (pix_o),
        .font_ld_o (font_ld_o)
    );

    function automatic logic [11:0] glyph(input int c);
        return 12'((c * 397 + 1443) % 4096);
    endfunction

    function automatic logic [11:0] junk(input int n);
        return 12'((n * 2741 + 77) % 4096) ^ 12'hFFF;
    endfunction

    // True if the edge after gn+1 edges starts a cell; returns that cell
    function automatic bit cell_start(input int k, output int c);
        int L;
        L = 12 * gw;
        c = 0;
        if (!gvalid || k < gS) return 1'b0;
        if (((k - gS) % L) != 0) return 1'b0;
        c = (k - gS) / L;
        return (c < 24);
    endfunction

    task automatic check(input string tag);
        logic eh, ep, el;
        int   ec, ed, m, L, cc;
        eh = 1'b0; ep = 1'b0; ec = 0; ed = 0;
        L = 12 * gw;
        if (gvalid && gn >= gS) begin
            m = gn - gS;
            if (m < 24 * L) begin
                eh = 1'b1;
                ec = m / L;
                ed = (m % L) / gw;
                ep = glyph(ec)[11 - ed];
            end
        end
        el = cell_start(gn + 1, cc);
        vecs++;
        if (hact_o !== eh) begin
            errs++;
            $display("FAIL %s R2 hact act=%0b exp=%0b n=%0d", tag, hact_o, eh, gn);
        end
        if (col_o !== 5'(ec)) begin
            errs++;
            $display("FAIL %s %s col act=%0d exp=%0d n=%0d", tag, (gw == 2) ? "R5" : "R4", col_o, ec, gn);
        end
        if (dot_o !== 4'(ed)) begin
            errs++;
            $display("FAIL %s %s dot act=%0d exp=%0d n=%0d", tag, (gw == 2) ? "R5" : "R4", dot_o, ed, gn);
        end
        if (pix_o !== ep) begin
            errs++;
            $display("FAIL %s %s pix act=%0b exp=%0b n=%0d", tag, eh ? "R7" : "R8", pix_o, ep, gn);
        end
        if (font_ld_o !== el) begin
            errs++;
            $display("FAIL %s R7 load act=%0b exp=%0b n=%0d", tag, font_ld_o, el, gn);
        end
    endtask

    // One cycle with inputs held
    task automatic tick(input string tag);
        @(negedge clk);
        check(tag);
        @(posedge clk);
        gn++;
    endtask

    // One line: sync fall, low for plow edges, len edges in total
    task automatic run_line(input int h, input int d, input int len,
                            input int plow, input string tag);
        int cc;
        @(negedge clk);
        check(tag);
        hsync_n  = 1'b0;
        hpos     = 5'(h);
        dbl_w    = d[0];
        font_row = junk(h);
        @(posedge clk);
        gvalid = 1'b1;
        gS     = h * 6 + 61;
        gw     = d + 1;
        gn     = 0;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            check(tag);
            hpos    = 5'(h) ^ 5'(i);       // R3: late changes must not matter
            dbl_w   = ~d[0];
            hsync_n = (gn + 1 < plow) ? 1'b0 : 1'b1;
            if (cell_start(gn + 1, cc)) font_row = glyph(cc);
            else                        font_row = junk(gn);
            @(posedge clk);
            gn++;
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        hsync_n  = 1'b1;
        hpos     = '0;
        dbl_w    = 1'b0;
        font_row = '0;
        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            check("R10");
        end
        rst_n = 1'b1;
        // R6: idle with no sync
        repeat (5) tick("R6");
        // Full sweep of position codes in both widths (R2 R3 R4 R5 R7 R8)
        for (int d = 0; d < 2; d++) begin
            for (int h = 0; h < 32; h++) begin
                run_line(h, d, h * 6 + 61 + 288 * (d + 1) + 6, 3, "R3");
            end
        end
        // R9: restart inside the window, then inside the lead-in
        run_line(4, 0, 85 + 100, 3, "R9");
        run_line(31, 1, 150, 5, "R9");
        run_line(2, 0, 73 + 288 + 6, 3, "R9");
        // R1: sync held low across the window start
        run_line(1, 1, 67 + 576 + 6, 300, "R1");
        // R10: reset in the middle of a window
        run_line(7, 0, 103 + 30, 3, "R10");
        @(negedge clk);
        check("R10");
        rst_n   = 1'b0;
        hsync_n = 1'b1;
        @(posedge clk);
        gvalid = 1'b0;
        @(negedge clk);
        check("R10");
        rst_n = 1'b1;
        @(posedge clk);
        repeat (4) tick("R6");
        run_line(0, 0, 61 + 288 + 6, 3, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog R1 act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule